// File: doc/BRIEF.md
# Serial NOR Flash Protection Guard

This block is the slave-side command front end of a serial NOR flash with the array left out. It accepts SPI mode-0 frames on chip select, serial clock and data-in, and it drives data-out. It holds a write-enable latch and two 8-bit status registers. Every command is judged when chip select rises. Whether a status write, a program or an erase is allowed depends on the write-enable latch, on protect bits inside the status registers, and on the level of the write-protect pin at that moment. The flash array is not modelled. An accepted program or erase produces only a one-cycle strobe, which the surrounding logic or a bench can count.

The serial inputs are oversampled by the system clock through synchronizers. The system clock must run at least eight times faster than the serial clock. Status register 1 reads back with the write-enable latch in bit 1 and an always-idle busy flag in bit 0. Its upper six bits are the stored protect bits, with bit 7 acting as the status-protect bit. In status register 2, bit 0 is the second status-protect bit and bit 6 is the complement bit that makes the whole array read-only.

Top module: `spi_flash_guard`

## Requirements
- R1: After reset both status registers read 0x00, the write-enable latch is clear, and neither strobe is asserted.
- R2: A one-byte frame of opcode 0x06 sets the write-enable latch, and a one-byte frame of 0x04 clears it. The latch is visible as bit 1 of status register 1.
- R3: Opcode 0x05 returns status register 1 as {stored bits 7:2, latch, 0}, and opcode 0x35 returns status register 2. Data leaves MSB first and changes on serial clock falling edges, starting at the falling edge after the eighth opcode bit. The byte repeats for as long as chip select stays low. MISO is 0 whenever no read data is being driven.
- R4: A three-byte frame of opcode 0x01 with the latch set writes byte 1 bits 7:2 into status register 1 and all of byte 2 into status register 2. It then clears the latch.
- R5: While status register 1 bit 7 is 1, status register 2 bit 0 is 0 and the write-protect pin is low, a 0x01 frame is rejected. Both registers and the latch stay unchanged.
- R6: Three kinds of array frame exist. Program is 0x02 with at least ADDR_BYTES+2 bytes. Sector erase is 0x20 with exactly ADDR_BYTES+1 bytes. Chip erase is 0xC7 with exactly one byte. Such a frame is accepted only while the latch is set. On acceptance, prog_accept or erase_accept pulses for exactly one clock after chip select rises, and the latch clears. A rejected frame changes nothing.
- R7: When status register 2 bit 6 is 1 and the R5 lock condition holds, every program and erase frame is rejected, with no strobe and the latch unchanged.
- R8: A frame with the wrong byte count for its opcode, or one that ends part-way through a byte, changes no state and produces no strobe.
- R9: Driving the write-protect pin high, or setting status register 2 bit 0, removes both the R5 lock and the R7 lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; frame ends on its rising edge |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on sclk rising edges |
| wp_n | input | 1 | Write-protect pin, low means protect |
| miso | output | 1 | Serial data out for status reads |
| prog_accept | output | 1 | One-cycle pulse for an accepted program |
| erase_accept | output | 1 | One-cycle pulse for an accepted sector or chip erase |

## Verification
A wrong latch or protect bit shows up at the next status read. It also shows up as a missing or extra strobe on the next array frame, a few system clocks after chip select rises. A lock that engages or releases wrongly appears as a status write that lands or fails to land, and the read that follows at once exposes it. A wrong bit or byte counter shows up as a truncated frame that still acts, or as read data shifted by one position, both within the same frame.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

  localparam int CNT_W = 4;

  localparam logic [7:0] OP_WR_EN      = 8'h06;
  localparam logic [7:0] OP_WR_DIS     = 8'h04;
  localparam logic [7:0] OP_RD_STAT1   = 8'h05;
  localparam logic [7:0] OP_RD_STAT2   = 8'h35;
  localparam logic [7:0] OP_WR_STAT    = 8'h01;
  localparam logic [7:0] OP_PAGE_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT_ERASE = 8'h20;
  localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET_WEL,
    ACT_CLR_WEL,
    ACT_WR_STAT,
    ACT_PROG,
    ACT_ERASE
  } act_e;

endpackage

// File: rtl/spi_guard_rx.sv
module spi_guard_rx
  import spi_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  input  logic             wp_n,
  output logic             cs_idle,
  output logic             wp_level,
  output logic             sclk_fall,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx,
  output logic             frame_end,
  output logic [CNT_W-1:0] frame_bytes,
  output logic             frame_aligned
);

  localparam logic [3:0]       SYNC_RST = 4'b1001;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic sclk_s, mosi_s;
  logic sclk_prev_q, cs_prev_q;
  logic sclk_rise;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{SYNC_RST}};
    end else begin
      sync_q[0] <= {cs_n, sclk, mosi, wp_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign cs_idle  = sync_q[SYNC_STAGES-1][3];
  assign sclk_s   = sync_q[SYNC_STAGES-1][2];
  assign mosi_s   = sync_q[SYNC_STAGES-1][1];
  assign wp_level = sync_q[SYNC_STAGES-1][0];

  assign sclk_rise = sclk_s & ~sclk_prev_q & ~cs_idle;
  assign sclk_fall = ~sclk_s & sclk_prev_q & ~cs_idle;
  assign frame_end = cs_idle & ~cs_prev_q;

  always_comb begin
    bit_d = bit_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (cs_idle) begin
      bit_d = '0;
      cnt_d = '0;
    end else if (sclk_rise) begin
      sh_d  = {sh_q[6:0], mosi_s};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7 && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  assign byte_done     = sclk_rise & (bit_q == 3'd7);
  assign byte_val      = {sh_q[6:0], mosi_s};
  assign byte_idx      = cnt_q;
  assign frame_bytes   = cnt_q;
  assign frame_aligned = (bit_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
      bit_q       <= '0;
      sh_q        <= '0;
      cnt_q       <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      cs_prev_q   <= cs_idle;
      bit_q       <= bit_d;
      sh_q        <= sh_d;
      cnt_q       <= cnt_d;
    end
  end

endmodule

// File: rtl/spi_guard_dec.sv
module spi_guard_dec
  import spi_guard_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_done,
  input  logic [7:0]       byte_val,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] frame_bytes,
  input  logic             frame_aligned,
  output act_e             act,
  output logic [5:0]       stat1_wdata,
  output logic [7:0]       stat2_wdata,
  output logic             rd_load,
  output logic             rd_pick2
);

  localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_STAT  = CNT_W'(3);
  localparam logic [CNT_W-1:0] LEN_PROG  = CNT_W'(ADDR_BYTES + 2);
  localparam logic [CNT_W-1:0] LEN_ERASE = CNT_W'(ADDR_BYTES + 1);

  logic [7:0] op_q, op_d;
  logic [5:0] b1_q, b1_d;
  logic [7:0] b2_q, b2_d;
  act_e       act_q, act_d;

  always_comb begin
    op_d = op_q;
    b1_d = b1_q;
    b2_d = b2_q;
    if (byte_done) begin
      if (byte_idx == CNT_W'(0)) op_d = byte_val;
      if (byte_idx == CNT_W'(1)) b1_d = byte_val[7:2];
      if (byte_idx == CNT_W'(2)) b2_d = byte_val;
    end
  end

  always_comb begin
    act_d = ACT_NONE;
    if (frame_end && frame_aligned) begin
      case (op_q)
        OP_WR_EN:      if (frame_bytes == LEN_ONE)   act_d = ACT_SET_WEL;
        OP_WR_DIS:     if (frame_bytes == LEN_ONE)   act_d = ACT_CLR_WEL;
        OP_WR_STAT:    if (frame_bytes == LEN_STAT)  act_d = ACT_WR_STAT;
        OP_PAGE_PROG:  if (frame_bytes >= LEN_PROG)  act_d = ACT_PROG;
        OP_SECT_ERASE: if (frame_bytes == LEN_ERASE) act_d = ACT_ERASE;
        OP_CHIP_ERASE: if (frame_bytes == LEN_ONE)   act_d = ACT_ERASE;
        default:       act_d = ACT_NONE;
      endcase
    end
  end

  assign rd_load  = byte_done && (byte_idx == CNT_W'(0)) &&
                    (byte_val == OP_RD_STAT1 || byte_val == OP_RD_STAT2);
  assign rd_pick2 = (byte_val == OP_RD_STAT2);

  assign act         = act_q;
  assign stat1_wdata = b1_q;
  assign stat2_wdata = b2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      b1_q  <= '0;
      b2_q  <= '0;
      act_q <= ACT_NONE;
    end else begin
      op_q  <= op_d;
      b1_q  <= b1_d;
      b2_q  <= b2_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/spi_guard_regs.sv
module spi_guard_regs
  import spi_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  act_e       act,
  input  logic [5:0] stat1_wdata,
  input  logic [7:0] stat2_wdata,
  input  logic       wp_level,
  output logic [7:0] stat1_view,
  output logic [7:0] stat2_val,
  output logic       wel,
  output logic       status_locked,
  output logic       array_ro,
  output logic       prog_accept,
  output logic       erase_accept
);

  logic [5:0] s1_q, s1_d;
  logic [7:0] s2_q, s2_d;
  logic       wel_q, wel_d;
  logic       prog_q, prog_d;
  logic       erase_q, erase_d;

  assign status_locked = s1_q[5] & ~s2_q[0] & ~wp_level;
  assign array_ro      = s2_q[6] & status_locked;

  always_comb begin
    s1_d    = s1_q;
    s2_d    = s2_q;
    wel_d   = wel_q;
    prog_d  = 1'b0;
    erase_d = 1'b0;
    case (act)
      ACT_SET_WEL: wel_d = 1'b1;
      ACT_CLR_WEL: wel_d = 1'b0;
      ACT_WR_STAT: begin
        if (wel_q && !status_locked) begin
          s1_d  = stat1_wdata;
          s2_d  = stat2_wdata;
          wel_d = 1'b0;
        end
      end
      ACT_PROG: begin
        if (wel_q && !array_ro) begin
          prog_d = 1'b1;
          wel_d  = 1'b0;
        end
      end
      ACT_ERASE: begin
        if (wel_q && !array_ro) begin
          erase_d = 1'b1;
          wel_d   = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= '0;
      s2_q    <= '0;
      wel_q   <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      s1_q    <= s1_d;
      s2_q    <= s2_d;
      wel_q   <= wel_d;
      prog_q  <= prog_d;
      erase_q <= erase_d;
    end
  end

  assign stat1_view   = {s1_q, wel_q, 1'b0};
  assign stat2_val    = s2_q;
  assign wel          = wel_q;
  assign prog_accept  = prog_q;
  assign erase_accept = erase_q;

endmodule

// File: rtl/spi_guard_tx.sv
module spi_guard_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_idle,
  input  logic       sclk_fall,
  input  logic       rd_load,
  input  logic       rd_pick2,
  input  logic [7:0] stat1_view,
  input  logic [7:0] stat2_val,
  output logic       miso
);

  logic [7:0] tx_q, tx_d;
  logic       on_q, on_d;
  logic       out_q, out_d;

  always_comb begin
    tx_d  = tx_q;
    on_d  = on_q;
    out_d = out_q;
    if (cs_idle) begin
      on_d  = 1'b0;
      out_d = 1'b0;
    end else if (rd_load) begin
      tx_d = rd_pick2 ? stat2_val : stat1_view;
      on_d = 1'b1;
    end else if (sclk_fall && on_q) begin
      out_d = tx_q[7];
      tx_d  = {tx_q[6:0], tx_q[7]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      on_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      on_q  <= on_d;
      out_q <= out_d;
    end
  end

  assign miso = out_q;

endmodule

// File: rtl/spi_flash_guard.sv
module spi_flash_guard
  import spi_guard_pkg::*;
#(
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic prog_accept,
  output logic erase_accept
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             cs_idle, wp_level, sclk_fall;
  logic             byte_done, frame_end, frame_aligned;
  logic [7:0]       byte_val;
  logic [CNT_W-1:0] byte_idx, frame_bytes;
  act_e             act;
  logic [5:0]       stat1_wdata;
  logic [7:0]       stat2_wdata;
  logic             rd_load, rd_pick2;
  logic [7:0]       stat1_view, stat2_val;
  logic             wel, status_locked, array_ro;

  spi_guard_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_sync_q), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .cs_idle(cs_idle), .wp_level(wp_level), .sclk_fall(sclk_fall),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx),
    .frame_end(frame_end), .frame_bytes(frame_bytes), .frame_aligned(frame_aligned)
  );

  spi_guard_dec #(.ADDR_BYTES(ADDR_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_sync_q), .byte_done(byte_done), .byte_val(byte_val),
    .byte_idx(byte_idx), .frame_end(frame_end), .frame_bytes(frame_bytes),
    .frame_aligned(frame_aligned), .act(act), .stat1_wdata(stat1_wdata),
    .stat2_wdata(stat2_wdata), .rd_load(rd_load), .rd_pick2(rd_pick2)
  );

  spi_guard_regs u_regs (
    .clk(clk), .rst_n(rst_sync_q), .act(act), .stat1_wdata(stat1_wdata),
    .stat2_wdata(stat2_wdata), .wp_level(wp_level), .stat1_view(stat1_view),
    .stat2_val(stat2_val), .wel(wel), .status_locked(status_locked),
    .array_ro(array_ro), .prog_accept(prog_accept), .erase_accept(erase_accept)
  );

  spi_guard_tx u_tx (
    .clk(clk), .rst_n(rst_sync_q), .cs_idle(cs_idle), .sclk_fall(sclk_fall),
    .rd_load(rd_load), .rd_pick2(rd_pick2), .stat1_view(stat1_view),
    .stat2_val(stat2_val), .miso(miso)
  );

endmodule

// File: rtl/spi_flash_guard_chk.sv
module spi_flash_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_idle,
  input logic       miso,
  input logic       wel,
  input logic       status_locked,
  input logic       array_ro,
  input logic [7:0] stat1_view,
  input logic [7:0] stat2_val,
  input logic       prog_accept,
  input logic       erase_accept
);

  a_r6_prog_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    prog_accept |-> $past(wel));

  a_r6_erase_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    erase_accept |-> $past(wel));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_accept || erase_accept) |=> !(prog_accept || erase_accept));

  a_r6_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_accept || erase_accept) |-> !wel);

  a_r5_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    status_locked |=> ($stable(stat1_view[7:2]) && $stable(stat2_val)));

  a_r7_ro_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    array_ro |=> !(prog_accept || erase_accept));

  a_r3_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !miso);

endmodule

bind spi_flash_guard spi_flash_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .miso(miso), .wel(wel),
  .status_locked(status_locked), .array_ro(array_ro), .stat1_view(stat1_view),
  .stat2_val(stat2_val), .prog_accept(prog_accept), .erase_accept(erase_accept)
);

// File: tb/spi_flash_guard_test.sv
module spi_flash_guard_test;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso, prog_accept, erase_accept;

  always #5 clk = ~clk;

  spi_flash_guard uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .prog_accept(prog_accept), .erase_accept(erase_accept)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int seen_prog = 0;
  int seen_erase = 0;
  int exp_prog = 0;
  int exp_erase = 0;
  logic [5:0] exp_hi = '0;
  logic [7:0] exp_sr2 = '0;
  logic exp_wel = 1'b0;
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];
  bit finished = 0;

  always @(posedge clk) begin
    if (prog_accept) seen_prog++;
    if (erase_accept) seen_erase++;
  end

  function automatic logic [7:0] sr1_exp();
    return {exp_hi, exp_wel, 1'b0};
  endfunction

  function automatic void model(logic [7:0] op, int nb, int extra,
                                logic [7:0] d1, logic [7:0] d2);
    logic lk, ro;
    lk = exp_hi[5] & ~exp_sr2[0] & ~wp_n;
    ro = exp_sr2[6] & lk;
    if (extra != 0) return;
    case (op)
      8'h06: if (nb == 1) exp_wel = 1'b1;
      8'h04: if (nb == 1) exp_wel = 1'b0;
      8'h01: if (nb == 3 && exp_wel && !lk) begin
        exp_hi = d1[7:2]; exp_sr2 = d2; exp_wel = 1'b0;
      end
      8'h02: if (nb >= 5 && exp_wel && !ro) begin exp_prog++; exp_wel = 1'b0; end
      8'h20: if (nb == 4 && exp_wel && !ro) begin exp_erase++; exp_wel = 1'b0; end
      8'hC7: if (nb == 1 && exp_wel && !ro) begin exp_erase++; exp_wel = 1'b0; end
      default: ;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_frame(input int nb, input int extra);
    @(negedge clk);
    cs_n = 1'b0;
    half();
    for (int i = 0; i < nb * 8 + extra; i++) begin
      mosi = tx_buf[i / 8][7 - (i % 8)];
      half();
      rx_buf[i / 8][7 - (i % 8)] = miso;
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
    mosi = 1'b0;
    half();
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic read_reg(input bit second, input int nb, output logic [7:0] first_val,
                          output logic [7:0] last_val);
    tx_buf[0] = second ? 8'h35 : 8'h05;
    run_frame(nb, 0);
    first_val = rx_buf[1];
    last_val = rx_buf[nb - 1];
  endtask

  task automatic verify(input string tag);
    logic [7:0] a, b;
    check({tag, " R3 miso idle"}, 32'(miso), 32'd0);
    read_reg(1'b0, 2, a, b);
    check({tag, " status1"}, 32'(a), 32'(sr1_exp()));
    read_reg(1'b1, 2, a, b);
    check({tag, " status2"}, 32'(a), 32'(exp_sr2));
    check({tag, " prog strobes"}, 32'(seen_prog), 32'(exp_prog));
    check({tag, " erase strobes"}, 32'(seen_erase), 32'(exp_erase));
  endtask

  task automatic cmd(input string tag, input logic [7:0] op, input int nb, input int extra,
                     input logic [7:0] d1, input logic [7:0] d2);
    tx_buf[0] = op;
    tx_buf[1] = d1;
    tx_buf[2] = d2;
    for (int k = 3; k < 8; k++) tx_buf[k] = 8'($urandom);
    run_frame(nb, extra);
    model(op, nb, extra, d1, d2);
    verify(tag);
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk);
    wp_n = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    check("R1 strobes low", 32'({prog_accept, erase_accept}), 32'd0);
    verify("R1 reset");

    cmd("R2 set latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R2 clear latch", 8'h04, 1, 0, 8'h00, 8'h00);
    cmd("R6 prog without latch", 8'h02, 5, 0, 8'h12, 8'h34);
    cmd("R6 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R6 prog", 8'h02, 5, 0, 8'h12, 8'h34);
    cmd("R6 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R6 sector erase", 8'h20, 4, 0, 8'h01, 8'h00);
    cmd("R6 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R6 chip erase", 8'hC7, 1, 0, 8'h00, 8'h00);
    cmd("R4 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R4 status write", 8'h01, 3, 0, 8'hFF, 8'hA5);

    cmd("R8 two-byte enable", 8'h06, 2, 0, 8'h00, 8'h00);
    cmd("R8 partial enable", 8'h06, 1, 3, 8'h00, 8'h00);
    cmd("R8 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R8 short status write", 8'h01, 2, 0, 8'h00, 8'h00);
    cmd("R8 long erase", 8'h20, 5, 0, 8'h00, 8'h00);
    cmd("R8 short prog", 8'h02, 4, 0, 8'h00, 8'h00);
    cmd("R8 prog cut mid-byte", 8'h02, 5, 5, 8'h00, 8'h00);

    cmd("R4 lock setup", 8'h01, 3, 0, 8'h80, 8'h40);
    set_wp(1'b0);
    cmd("R5 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R5 locked status write", 8'h01, 3, 0, 8'h00, 8'h00);
    cmd("R7 locked prog", 8'h02, 6, 0, 8'h00, 8'h00);
    cmd("R7 locked erase", 8'hC7, 1, 0, 8'h00, 8'h00);
    set_wp(1'b1);
    cmd("R9 pin high prog", 8'h02, 5, 0, 8'h00, 8'h00);
    cmd("R9 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R9 set srp1", 8'h01, 3, 0, 8'h80, 8'h41);
    set_wp(1'b0);
    cmd("R9 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R9 srp1 prog", 8'h02, 5, 0, 8'h00, 8'h00);
    cmd("R9 latch", 8'h06, 1, 0, 8'h00, 8'h00);
    cmd("R9 srp1 status write", 8'h01, 3, 0, 8'h9C, 8'h00);

    read_reg(1'b0, 4, a, b);
    check("R3 repeated byte", 32'(b), 32'(sr1_exp()));
    set_wp(1'b1);

    for (int it = 0; it < 90; it++) begin
      logic [7:0] ops [9];
      int sel, nb, extra;
      logic [7:0] op;
      ops = '{8'h06, 8'h04, 8'h05, 8'h35, 8'h01, 8'h02, 8'h20, 8'hC7, 8'h9F};
      set_wp(($urandom % 3) != 0);
      sel = int'($urandom % 9);
      op = ops[sel];
      case (op)
        8'h01: nb = 3;
        8'h02: nb = 5 + int'($urandom % 2);
        8'h20: nb = 4;
        8'h05, 8'h35: nb = 2;
        default: nb = 1;
      endcase
      if (($urandom % 5) == 0) nb = nb + int'($urandom % 3) - 1;
      if (nb < 1) nb = 1;
      extra = (($urandom % 6) == 0) ? 1 + int'($urandom % 7) : 0;
      if (op != 8'h06 && ($urandom % 3) == 0) cmd("R2 random latch", 8'h06, 1, 0, 8'h00, 8'h00);
      cmd("R6 R8 random", op, nb, extra, 8'($urandom), 8'($urandom));
    end

    summary();
  end

endmodule